// File: doc/BRIEF.md
# NAND Bus Cycle Timing Generator

This block sits on the host side of a parallel NAND flash bus. It turns one-word requests (command byte, address byte, data write, data read) into bus cycles with correct timing. It drives the chip enable, the two latch enables, the write strobe, the read strobe and the output enable of the bidirectional data bus, and it reads the active-low ready/busy line. Each timing minimum is given in nanoseconds. At elaboration it is rounded up to whole clock cycles, and no phase is ever shorter than one cycle. Two timing profiles, normal and relaxed, are built in. A profile input, sampled when a request is accepted, selects which one applies to that request.

Every request passes through the same sequence. First the generator waits for ready/busy to read high. It then drives a strobe-low phase and then a strobe-high phase, with chip enable held low through both. Last, it returns a response. On a read, the strobe-low phase lasts at least as long as the read-access delay and the chip-enable access delay, so data is sampled when the read strobe rises. If the target stays busy for longer than a configurable number of cycles, the request ends with an error response and the bus is never touched. Requests and responses use valid/ready handshakes.

Top module: `nand_cycle_gen`

## Requirements
- R1: After reset, nand_ce_n, nand_we_n and nand_re_n are high, nand_cle, nand_ale and nand_io_oe are low, req_ready is high and rsp_valid is low.
- R2: A command request (req_op = 0) drives nand_cle high and nand_ale low during its cycle. The low eight bits of req_data appear on nand_io_out and all upper bits are zero, with nand_io_oe high while nand_we_n is low.
- R3: An address request (req_op = 1) drives nand_ale high and nand_cle low. Only the low eight bits are driven, as in R2.
- R4: A data write request (req_op = 2) drives the full BUS_W-bit req_data on nand_io_out, with both latch enables low.
- R5: A data read request (req_op = 3) pulses nand_re_n low with nand_io_oe low throughout. It returns in rsp_data the value nand_io_in holds at the clock edge where nand_re_n rises.
- R6: In the normal profile (prof_relaxed = 0) with a 5 ns clock, a write cycle has 5 cycles of nand_we_n low and 5 cycles high. A read cycle has 9 cycles of nand_re_n low and 3 high. The high phase is counted while nand_ce_n is still low.
- R7: In the relaxed profile (prof_relaxed = 1) with a 5 ns clock, a write cycle has 8 low and 4 high. A read cycle has 11 low and 4 high.
- R8: nand_ce_n only falls when nand_rb_n was high in the previous cycle. A request issued while the line is low waits until it goes high.
- R9: If nand_rb_n stays low for TIMEOUT_CYC cycles after a request is accepted, the generator returns a response with rsp_err = 1 and drives no bus cycle.
- R10: rsp_valid, rsp_data and rsp_err hold steady until rsp_ready is seen. req_ready stays low from request acceptance until the response is taken.
- R11: nand_we_n and nand_re_n are never low together, and nand_cle and nand_ale are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prof_relaxed | input | 1 | Profile select, 1 = relaxed, sampled with each request |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high with req_valid |
| req_op | input | 2 | 0 command, 1 address, 2 data write, 3 data read |
| req_data | input | BUS_W | Byte or word to write |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken |
| rsp_data | output | BUS_W | Read word, zero for writes |
| rsp_err | output | 1 | Busy timeout, no bus cycle made |
| nand_ce_n | output | 1 | Chip enable, active low |
| nand_cle | output | 1 | Command latch enable |
| nand_ale | output | 1 | Address latch enable |
| nand_we_n | output | 1 | Write strobe, target latches on its rising edge |
| nand_re_n | output | 1 | Read strobe, active low |
| nand_rb_n | input | 1 | Ready/busy, low while busy, assumed synchronous |
| nand_io_out | output | BUS_W | Bus value driven by the host |
| nand_io_oe | output | 1 | Host drives the bus when high |
| nand_io_in | input | BUS_W | Bus value returned by the target |

## Verification
The main function is exercised with all four request kinds under both profiles. This separates the latch-enable decoding, the byte-versus-word driving and the four pulse-length pairs. A command whose upper input bits are set shows that those bits are zeroed on the bus. A read model returns valid data only while the read strobe is low, so sampling after the rise is caught. A target held busy for a while shows that chip enable waits, and one held busy past the limit gives an error response with no bus activity. A response left untaken for several cycles shows that it holds.

// File: rtl/nand_cg_pkg.sv
`timescale 1ns/1ps
package nand_cg_pkg;

  typedef enum logic [1:0] {
    OP_CMD   = 2'd0,
    OP_ADDR  = 2'd1,
    OP_WDATA = 2'd2,
    OP_RDATA = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_LOW, ST_HIGH, ST_RESP
  } st_e;

  // Round a nanosecond minimum up to clock cycles, never below one.
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // High phase: its own minimum, or whatever the full cycle still needs.
  function automatic int high_phase(input int hi_ns, input int cyc_ns,
                                    input int low_cyc, input int clk_ns);
    return max2(ns_to_cyc(hi_ns, clk_ns), ns_to_cyc(cyc_ns, clk_ns) - low_cyc);
  endfunction

  // Read low phase: long enough for pulse width and both access delays.
  function automatic int read_low(input int lo_ns, input int rea_ns,
                                  input int cea_ns, input int clk_ns);
    return max2(ns_to_cyc(lo_ns, clk_ns),
                max2(ns_to_cyc(rea_ns, clk_ns), ns_to_cyc(cea_ns, clk_ns)));
  endfunction

endpackage

// File: rtl/nand_cg_timing.sv
`timescale 1ns/1ps
module nand_cg_timing
  import nand_cg_pkg::*;
#(
  parameter int CLK_NS = 5,
  parameter int CW     = 8,
  // normal profile, ns
  parameter int N_WLO = 25, parameter int N_WHI = 15, parameter int N_WCY = 50,
  parameter int N_RLO = 25, parameter int N_RHI = 15, parameter int N_RCY = 50,
  parameter int N_REA = 30, parameter int N_CEA = 45,
  // relaxed profile, ns
  parameter int X_WLO = 40, parameter int X_WHI = 20, parameter int X_WCY = 60,
  parameter int X_RLO = 40, parameter int X_RHI = 20, parameter int X_RCY = 60,
  parameter int X_REA = 40, parameter int X_CEA = 55
) (
  input  logic          relaxed,
  input  logic          is_read,
  output logic [CW-1:0] low_cyc,
  output logic [CW-1:0] high_cyc
);
  localparam int NWL = ns_to_cyc(N_WLO, CLK_NS);
  localparam int NWH = high_phase(N_WHI, N_WCY, NWL, CLK_NS);
  localparam int NRL = read_low(N_RLO, N_REA, N_CEA, CLK_NS);
  localparam int NRH = high_phase(N_RHI, N_RCY, NRL, CLK_NS);
  localparam int XWL = ns_to_cyc(X_WLO, CLK_NS);
  localparam int XWH = high_phase(X_WHI, X_WCY, XWL, CLK_NS);
  localparam int XRL = read_low(X_RLO, X_REA, X_CEA, CLK_NS);
  localparam int XRH = high_phase(X_RHI, X_RCY, XRL, CLK_NS);

  always_comb begin
    unique case ({relaxed, is_read})
      2'b00:   begin low_cyc = CW'(NWL); high_cyc = CW'(NWH); end
      2'b01:   begin low_cyc = CW'(NRL); high_cyc = CW'(NRH); end
      2'b10:   begin low_cyc = CW'(XWL); high_cyc = CW'(XWH); end
      default: begin low_cyc = CW'(XRL); high_cyc = CW'(XRH); end
    endcase
  end
endmodule

// File: rtl/nand_cg_phase_cnt.sv
`timescale 1ns/1ps
module nand_cg_phase_cnt #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] val,
  output logic          done
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= val - CW'(1);
    else if (cnt != '0)   cnt <= cnt - CW'(1);
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/nand_cg_busy_wait.sv
`timescale 1ns/1ps
module nand_cg_busy_wait #(
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic rb_n,
  output logic go,
  output logic expired
);
  localparam int TW = $clog2(TIMEOUT_CYC + 1);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (active && !rb_n) cnt <= cnt + TW'(1);
    else                     cnt <= '0;
  end

  assign go      = active && rb_n;
  assign expired = active && !rb_n && (cnt == TW'(TIMEOUT_CYC - 1));
endmodule

// File: rtl/nand_cycle_gen.sv
`timescale 1ns/1ps
module nand_cycle_gen
  import nand_cg_pkg::*;
#(
  parameter int BUS_W       = 8,
  parameter int CLK_NS      = 5,
  parameter int CW          = 8,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             prof_relaxed,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [BUS_W-1:0] req_data,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [BUS_W-1:0] rsp_data,
  output logic             rsp_err,
  output logic             nand_ce_n,
  output logic             nand_cle,
  output logic             nand_ale,
  output logic             nand_we_n,
  output logic             nand_re_n,
  input  logic             nand_rb_n,
  output logic [BUS_W-1:0] nand_io_out,
  output logic             nand_io_oe,
  input  logic [BUS_W-1:0] nand_io_in
);
  st_e              st;
  op_e              op_q;
  logic [BUS_W-1:0] dat_q, rdat_q;
  logic             rlx_q, err_q;
  logic [CW-1:0]    low_cyc, high_cyc, lo_run;
  logic             is_rd, in_bus, ph_done, ph_load, rb_go, rb_expired;

  assign is_rd  = (op_q == OP_RDATA);
  assign in_bus = (st == ST_LOW) || (st == ST_HIGH);

  nand_cg_timing #(.CLK_NS(CLK_NS), .CW(CW)) u_timing (
    .relaxed(rlx_q), .is_read(is_rd), .low_cyc(low_cyc), .high_cyc(high_cyc));

  assign ph_load = ((st == ST_WAIT) && rb_go) || ((st == ST_LOW) && ph_done);

  nand_cg_phase_cnt #(.CW(CW)) u_phase (
    .clk(clk), .rst_n(rst_n), .load(ph_load),
    .val((st == ST_LOW) ? high_cyc : low_cyc), .done(ph_done));

  nand_cg_busy_wait #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_busy (
    .clk(clk), .rst_n(rst_n), .active(st == ST_WAIT), .rb_n(nand_rb_n),
    .go(rb_go), .expired(rb_expired));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_IDLE; op_q <= OP_CMD; dat_q <= '0; rdat_q <= '0;
      rlx_q <= 1'b0; err_q <= 1'b0;
    end else begin
      unique case (st)
        ST_IDLE: if (req_valid) begin
          op_q <= op_e'(req_op); dat_q <= req_data; rlx_q <= prof_relaxed;
          rdat_q <= '0; err_q <= 1'b0; st <= ST_WAIT;
        end
        ST_WAIT: if (rb_expired) begin
          err_q <= 1'b1; st <= ST_RESP;
        end else if (rb_go) st <= ST_LOW;
        ST_LOW: if (ph_done) begin
          if (is_rd) rdat_q <= nand_io_in;   // sampled as RE rises
          st <= ST_HIGH;
        end
        ST_HIGH: if (ph_done) st <= ST_RESP;
        ST_RESP: if (rsp_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st == ST_IDLE);
  assign rsp_valid = (st == ST_RESP);
  assign rsp_data  = rdat_q;
  assign rsp_err   = err_q;

  assign nand_ce_n  = !in_bus;
  assign nand_cle   = in_bus && (op_q == OP_CMD);
  assign nand_ale   = in_bus && (op_q == OP_ADDR);
  assign nand_we_n  = !((st == ST_LOW) && !is_rd);
  assign nand_re_n  = !((st == ST_LOW) && is_rd);
  assign nand_io_oe = in_bus && !is_rd;

  always_comb begin
    nand_io_out = '0;
    if (op_q == OP_CMD || op_q == OP_ADDR) nand_io_out[7:0] = dat_q[7:0];
    else                                   nand_io_out = dat_q;
  end

  // Length of the current strobe-low run, for the pulse assertion.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        lo_run <= '0;
    else if (!nand_we_n || !nand_re_n) lo_run <= lo_run + CW'(1);
    else                               lo_run <= '0;
  end

  p_strobe_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(!nand_we_n && !nand_re_n));
  p_latch_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(nand_cle && nand_ale));
  p_ce_after_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(nand_ce_n) |-> $past(nand_rb_n));
  p_read_released_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !nand_re_n |-> !nand_io_oe);
  // R6 and R7: low run matches the selected profile when the strobe rises
  p_strobe_low_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(nand_we_n) || $rose(nand_re_n)) |-> (lo_run == low_cyc));
  p_rsp_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));
  p_err_no_bus_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> nand_ce_n);
endmodule

// File: tb/nand_cycle_gen_bench.sv
`timescale 1ns/1ps
module nand_cycle_gen_bench;
  localparam int BW = 16;
  localparam int TO = 40;

  logic clk = 1'b0, rst_n = 1'b0;
  logic prof_relaxed = 1'b0, req_valid = 1'b0, rsp_ready = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [BW-1:0] req_data = '0, model_rd = '0;
  logic req_ready, rsp_valid, rsp_err;
  logic [BW-1:0] rsp_data, nand_io_out, nand_io_in;
  logic nand_ce_n, nand_cle, nand_ale, nand_we_n, nand_re_n, nand_io_oe;
  logic nand_rb_n = 1'b1;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  // Target model: valid data only while the read strobe is low.
  assign nand_io_in = !nand_re_n ? model_rd : 16'hDEAD;

  nand_cycle_gen #(.BUS_W(BW), .CLK_NS(5), .TIMEOUT_CYC(TO)) u_nand_cycle_gen (
    .clk(clk), .rst_n(rst_n), .prof_relaxed(prof_relaxed),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_data(req_data), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .nand_ce_n(nand_ce_n),
    .nand_cle(nand_cle), .nand_ale(nand_ale), .nand_we_n(nand_we_n),
    .nand_re_n(nand_re_n), .nand_rb_n(nand_rb_n), .nand_io_out(nand_io_out),
    .nand_io_oe(nand_io_oe), .nand_io_in(nand_io_in));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Independent restatement of the cycle rounding.
  function automatic int cy(input int ns);
    int c = (ns + 4) / 5;
    return c < 1 ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return a > b ? a : b;
  endfunction

  typedef struct {
    int lo; int hi; logic rd; logic cle; logic ale; logic [BW-1:0] io; string tag;
  } exp_t;
  exp_t q[$];

  task automatic expect_timing(input logic rd, input logic rlx,
                               output int lo, output int hi);
    if (!rlx && !rd) begin lo = cy(25); hi = mx(cy(15), cy(50) - lo); end
    else if (!rlx)   begin lo = mx(cy(25), mx(cy(30), cy(45))); hi = mx(cy(15), cy(50) - lo); end
    else if (!rd)    begin lo = cy(40); hi = mx(cy(20), cy(60) - lo); end
    else             begin lo = mx(cy(40), mx(cy(40), cy(55))); hi = mx(cy(20), cy(60) - lo); end
  endtask

  task automatic do_op(input logic [1:0] op, input logic [BW-1:0] d, input logic rlx,
                       input logic [BW-1:0] rdv, input logic exp_err,
                       input int hold, input string tag);
    exp_t e;
    int lo, hi;
    expect_timing(op == 2'd3, rlx, lo, hi);
    e.lo = lo; e.hi = hi; e.rd = (op == 2'd3);
    e.cle = (op == 2'd0); e.ale = (op == 2'd1);
    e.io = (op < 2'd2) ? {8'h00, d[7:0]} : d;
    e.tag = tag;
    if (!exp_err) q.push_back(e);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_op = op; req_data = d; prof_relaxed = rlx; model_rd = rdv;
    @(negedge clk);
    req_valid = 1'b0;
    chk({tag, " R10 req_ready low while busy"}, req_ready, 1'b0);
    while (!rsp_valid) @(negedge clk);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R10 response held", {rsp_valid, req_ready}, 2'b10);
    end
    chk({tag, " err"}, rsp_err, exp_err);
    if (op == 2'd3 && !exp_err) chk({tag, " R5 read data"}, rsp_data, rdv);
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
  endtask

  // Monitor: measures each chip-enable window and compares with the queue.
  int we_lo, re_lo, both_hi, ce_falls;
  logic in_op = 1'b0, rb_prev = 1'b1, cle_s, ale_s, oe_bad, excl_bad, oe_we_bad;
  logic [BW-1:0] io_cap;
  always @(negedge clk) begin
    if (rst_n) begin
      if (!nand_ce_n) begin
        if (!in_op) begin
          in_op = 1'b1; ce_falls++;
          chk("R8 rb high before ce falls", rb_prev, 1'b1);
          we_lo = 0; re_lo = 0; both_hi = 0; cle_s = 0; ale_s = 0;
          oe_bad = 0; excl_bad = 0; oe_we_bad = 0; io_cap = '0;
        end
        if (!nand_we_n) begin we_lo++; io_cap = nand_io_out; if (!nand_io_oe) oe_we_bad = 1; end
        if (!nand_re_n) begin re_lo++; if (nand_io_oe) oe_bad = 1; end
        if (nand_we_n && nand_re_n) both_hi++;
        if ((!nand_we_n && !nand_re_n) || (nand_cle && nand_ale)) excl_bad = 1;
        cle_s = cle_s | nand_cle; ale_s = ale_s | nand_ale;
      end else if (in_op) begin
        exp_t e;
        in_op = 1'b0;
        if (q.size() == 0) chk("R9 unexpected bus cycle", 1, 0);
        else begin
          e = q.pop_front();
          chk({e.tag, " R11 exclusive strobes/latches"}, excl_bad, 0);
          chk({e.tag, " R2 R3 cle"}, cle_s, e.cle);
          chk({e.tag, " R2 R3 ale"}, ale_s, e.ale);
          chk({e.tag, " R6 R7 high len"}, both_hi, e.hi);
          if (e.rd) begin
            chk({e.tag, " R6 R7 re low len"}, re_lo, e.lo);
            chk({e.tag, " R5 bus released"}, {we_lo != 0, oe_bad}, 2'b00);
          end else begin
            chk({e.tag, " R6 R7 we low len"}, we_lo, e.lo);
            chk({e.tag, " R2 R4 io value"}, io_cap, e.io);
            chk({e.tag, " R4 oe during write"}, {re_lo != 0, oe_we_bad}, 2'b00);
          end
        end
      end
    end
    rb_prev = nand_rb_n;
  end

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(5 * 20000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int falls;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset strobes", {nand_ce_n, nand_we_n, nand_re_n}, 3'b111);
    chk("R1 reset latches/oe", {nand_cle, nand_ale, nand_io_oe}, 3'b000);
    chk("R1 reset handshake", {req_ready, rsp_valid}, 2'b10);

    do_op(2'd0, 16'hFF80, 1'b0, '0, 1'b0, 0, "R2 cmd normal");
    do_op(2'd1, 16'hAB12, 1'b0, '0, 1'b0, 0, "R3 addr normal");
    do_op(2'd2, 16'hA5C3, 1'b0, '0, 1'b0, 0, "R4 wdata normal");
    do_op(2'd3, 16'h0,    1'b0, 16'h3C5A, 1'b0, 0, "R5 read normal");
    do_op(2'd0, 16'h0070, 1'b1, '0, 1'b0, 0, "R7 cmd relaxed");
    do_op(2'd2, 16'h1234, 1'b1, '0, 1'b0, 0, "R7 wdata relaxed");
    do_op(2'd3, 16'h0,    1'b1, 16'hBEEF, 1'b0, 0, "R7 read relaxed");

    // R8: busy for 20 cycles, below the timeout
    nand_rb_n = 1'b0;
    fork
      do_op(2'd3, 16'h0, 1'b0, 16'h5A5A, 1'b0, 0, "R8 read after busy");
      begin
        repeat (20) begin
          @(negedge clk);
          chk("R8 ce held while busy", nand_ce_n, 1'b1);
        end
        nand_rb_n = 1'b1;
      end
    join

    // R9: busy past the limit
    falls = ce_falls;
    nand_rb_n = 1'b0;
    do_op(2'd2, 16'h7777, 1'b0, '0, 1'b1, 0, "R9 timeout");
    chk("R9 no bus cycle on timeout", ce_falls, falls);
    nand_rb_n = 1'b1;

    // R10: response left waiting
    do_op(2'd3, 16'h0, 1'b0, 16'hC001, 1'b0, 4, "R10 hold");

    repeat (5) @(negedge clk);
    chk("R2-queue drained", q.size(), 0);
    summary();
  end
endmodule